// File: doc/BRIEF.md
# Debug Transport Bridge over a JTAG Test Access Port

This block terminates a four-wire JTAG test access port and turns scans of one of its data registers into single read or write accesses on a small debug-module bus. A five-bit instruction register chooses what the data path holds between Capture-DR and Update-DR. The choices are a 32-bit identification word, a read-only 32-bit transport status word that reports the bus address width, a bus command register, or a one-bit bypass stage.

The bus command register holds an address, a 32-bit data word and a two-bit operation field. When a command is scanned in and the controller passes Update-DR, the bridge pulses a read or write strobe for one TCK period. It samples the module's response on the following rising edge. The next Capture-DR then hands back the address, the data and a status code, which replaces the operation field. All logic runs on TCK. The debug-bus side is therefore synchronous to TCK and answers within the strobe cycle.

Top module: `dbg_jtag_bridge`

## Requirements
- R1: The instruction register is 5 bits wide. Capture-IR loads 5'b00001, and Shift-IR shifts it LSB first toward TDO. The codes are decoded as follows: 0x01 selects identification, 0x10 selects the transport status word, 0x11 selects the bus command register, and every other code (0x1C included) selects bypass.
- R2: Entering Test-Logic-Reset loads the identification instruction. This happens on a low level of `trst_n`, or after five consecutive rising TCK edges with TMS high from any state. A following 32-bit data scan returns the `IDCODE` parameter.
- R3: The transport status word reads as (ABITS << 4) | 1. Bits [3:0] hold version 1 and bits [9:4] hold the address width. Data shifted into it during an update has no effect on later captures.
- R4: The bus command register is ABITS+34 bits wide, laid out as address [ABITS+33:34], data [33:2] and operation [1:0]. After reset its capture reads as all zeros, which means status 0 (success).
- R5: Operation 2 (write) drives `dbus_addr` and `dbus_wdata` with a `dbus_wr` pulse. The next capture returns the written data with status 0, or status 2 if `dbus_err` was high.
- R6: Operation 1 (read) pulses `dbus_rd`. The next capture returns `dbus_rdata` in the data field with status 0.
- R7: A read answered with `dbus_err` high returns status 2, and the data field keeps the data word of the command.
- R8: Operation 0 (no-op) and operation 3 (reserved) raise no strobe. Their next capture echoes the command's data, with status 0 for a no-op and status 2 for the reserved code.
- R9: In bypass, the data path is one bit that captures 0. TDI reappears on TDO one TCK later.
- R10: TDO changes only on the falling TCK edge. It carries bit 0 of the shifting register in Shift-IR or Shift-DR, and is 0 in every other state.
- R11: `dbus_rd` and `dbus_wr` are never high together. Each pulse lasts exactly one TCK cycle, starting on the rising edge that leaves Update-DR. The response is taken on the rising edge that ends the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; all state advances on its rising edge |
| tms | input | 1 | Test mode select, steers the TAP controller |
| tdi | input | 1 | Serial data into the selected register |
| trst_n | input | 1 | Asynchronous active-low TAP reset |
| tdo | output | 1 | Serial data out, updated on the falling TCK edge |
| dbus_addr | output | ABITS | Debug-bus address of the current command |
| dbus_wdata | output | 32 | Debug-bus write data |
| dbus_rd | output | 1 | One-cycle read strobe |
| dbus_wr | output | 1 | One-cycle write strobe |
| dbus_rdata | input | 32 | Read data returned by the debug module during the strobe |
| dbus_err | input | 1 | Access failure flag, valid during the strobe |

## Verification
The hardest state to reach is a bus response that has been latched but not yet shown. A command's outcome becomes visible only one full scan later, because it is read out by the capture that begins the next command scan. Each bus scenario therefore scans a command, then scans a no-op whose shifted-out word is compared with the expected address, data and status. Meanwhile a bench model of the debug module counts strobes and returns errors for addresses at or above 16, so that failing reads and writes can be provoked at will.

// File: rtl/dbg_jtag_pkg.sv
`timescale 1ns/100ps
package dbg_jtag_pkg;

  typedef enum logic [3:0] {
    TS_RESET    = 4'h0,
    TS_IDLE     = 4'h1,
    TS_SEL_DR   = 4'h2,
    TS_CAP_DR   = 4'h3,
    TS_SH_DR    = 4'h4,
    TS_EX1_DR   = 4'h5,
    TS_PAUSE_DR = 4'h6,
    TS_EX2_DR   = 4'h7,
    TS_UPD_DR   = 4'h8,
    TS_SEL_IR   = 4'h9,
    TS_CAP_IR   = 4'hA,
    TS_SH_IR    = 4'hB,
    TS_EX1_IR   = 4'hC,
    TS_PAUSE_IR = 4'hD,
    TS_EX2_IR   = 4'hE,
    TS_UPD_IR   = 4'hF
  } tap_state_t;

  localparam int IR_W = 5;
  localparam logic [IR_W-1:0] INS_IDCODE    = 5'h01;
  localparam logic [IR_W-1:0] INS_XPORT_CS  = 5'h10;
  localparam logic [IR_W-1:0] INS_BUS_ACC   = 5'h11;
  localparam logic [IR_W-1:0] INS_RESET_REQ = 5'h1C;
  localparam logic [IR_W-1:0] IR_CAPTURE    = 5'b00001;

  typedef enum logic [1:0] {
    SEL_IDENT  = 2'd0,
    SEL_CSR    = 2'd1,
    SEL_BUS    = 2'd2,
    SEL_BYPASS = 2'd3
  } dr_sel_t;

  localparam logic [1:0] OP_NOP   = 2'd0;
  localparam logic [1:0] OP_READ  = 2'd1;
  localparam logic [1:0] OP_WRITE = 2'd2;
  localparam logic [1:0] OP_RSVD  = 2'd3;
  localparam logic [1:0] ST_OK    = 2'd0;
  localparam logic [1:0] ST_FAIL  = 2'd2;

  function automatic tap_state_t tap_next(tap_state_t s, logic tms);
    tap_state_t n;
    case (s)
      TS_RESET:    n = tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:     n = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR:   n = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR:   n = tms ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:    n = tms ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR:   n = tms ? TS_UPD_DR : TS_PAUSE_DR;
      TS_PAUSE_DR: n = tms ? TS_EX2_DR : TS_PAUSE_DR;
      TS_EX2_DR:   n = tms ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR:   n = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR:   n = tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR:   n = tms ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:    n = tms ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR:   n = tms ? TS_UPD_IR : TS_PAUSE_IR;
      TS_PAUSE_IR: n = tms ? TS_EX2_IR : TS_PAUSE_IR;
      TS_EX2_IR:   n = tms ? TS_UPD_IR : TS_SH_IR;
      default:     n = tms ? TS_SEL_DR : TS_IDLE;
    endcase
    return n;
  endfunction

  // Transport status word: version in [3:0], address width in [9:4].
  function automatic logic [31:0] csr_word(int unsigned abits);
    return ((32'(abits) & 32'h3F) << 4) | 32'd1;
  endfunction

  function automatic dr_sel_t decode_ins(logic [IR_W-1:0] ins);
    dr_sel_t s;
    case (ins)
      INS_IDCODE:   s = SEL_IDENT;
      INS_XPORT_CS: s = SEL_CSR;
      INS_BUS_ACC:  s = SEL_BUS;
      default:      s = SEL_BYPASS;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dbg_tap_ctrl.sv
`timescale 1ns/100ps
module dbg_tap_ctrl
  import dbg_jtag_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_t state,
  output logic       to_reset,
  output logic       ev_cap_dr,
  output logic       ev_sh_dr,
  output logic       ev_upd_dr,
  output logic       ev_cap_ir,
  output logic       ev_sh_ir,
  output logic       ev_upd_ir
);

  tap_state_t nxt;

  assign nxt = tap_next(state, tms);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= TS_RESET;
    else         state <= nxt;
  end

  assign to_reset  = (nxt == TS_RESET);
  assign ev_cap_dr = (state == TS_CAP_DR);
  assign ev_sh_dr  = (state == TS_SH_DR);
  assign ev_upd_dr = (state == TS_UPD_DR);
  assign ev_cap_ir = (state == TS_CAP_IR);
  assign ev_sh_ir  = (state == TS_SH_IR);
  assign ev_upd_ir = (state == TS_UPD_IR);

  // Run length of TMS-high samples, saturating, for the reset-reach check.
  logic [2:0] tms_run;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)           tms_run <= 3'd0;
    else if (!tms)         tms_run <= 3'd0;
    else if (tms_run != 3'd5) tms_run <= tms_run + 3'd1;
  end

  assert_five_tms_reset_R2: assert property (@(posedge tck) disable iff (!trst_n)
    (tms_run == 3'd5) |-> (state == TS_RESET));

endmodule

// File: rtl/dbg_ir_reg.sv
`timescale 1ns/100ps
module dbg_ir_reg
  import dbg_jtag_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  logic            to_reset,
  input  logic            ev_cap_ir,
  input  logic            ev_sh_ir,
  input  logic            ev_upd_ir,
  input  tap_state_t      state,
  output logic [IR_W-1:0] ir_sr,
  output logic [IR_W-1:0] ir_q,
  output dr_sel_t         sel
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= IR_CAPTURE;
    end else if (ev_cap_ir) begin
      ir_sr <= IR_CAPTURE;
    end else if (ev_sh_ir) begin
      ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)        ir_q <= INS_IDCODE;
    else if (to_reset)  ir_q <= INS_IDCODE;
    else if (ev_upd_ir) ir_q <= ir_sr;
  end

  assign sel = decode_ins(ir_q);

  assert_reset_ident_R2: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_RESET) |-> (ir_q == INS_IDCODE));

  assert_ir_stable_R1: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_SH_IR || state == TS_CAP_IR) |=> $stable(ir_q));

endmodule

// File: rtl/dbg_dr_path.sv
`timescale 1ns/100ps
module dbg_dr_path
  import dbg_jtag_pkg::*;
#(
  parameter int          ABITS  = 7,
  parameter logic [31:0] IDCODE = 32'h1E57_A0C3,
  localparam int         DW     = ABITS + 34
) (
  input  logic          tck,
  input  logic          trst_n,
  input  logic          tdi,
  input  logic          ev_cap_dr,
  input  logic          ev_sh_dr,
  input  dr_sel_t       sel,
  input  logic [DW-1:0] cap_bus,
  output logic [DW-1:0] sr
);

  function automatic int unsigned len_of(dr_sel_t s);
    case (s)
      SEL_IDENT: return 32;
      SEL_CSR:   return 32;
      SEL_BUS:   return DW;
      default:   return 1;
    endcase
  endfunction

  // Right shift of the active length, TDI entering at the top active bit.
  function automatic logic [DW-1:0] shift_in(logic [DW-1:0] v, logic b, int unsigned len);
    logic [DW-1:0] mask;
    logic [DW-1:0] r;
    mask = (len >= DW) ? {DW{1'b1}} : ((DW'(1) << len) - DW'(1));
    r = (v >> 1) & mask;
    r[len-1] = b;
    return r;
  endfunction

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr <= '0;
    end else if (ev_cap_dr) begin
      case (sel)
        SEL_IDENT: sr <= DW'(IDCODE);
        SEL_CSR:   sr <= DW'(csr_word(ABITS));
        SEL_BUS:   sr <= cap_bus;
        default:   sr <= '0;
      endcase
    end else if (ev_sh_dr) begin
      sr <= shift_in(sr, tdi, len_of(sel));
    end
  end

  assert_bypass_zero_R9: assert property (@(posedge tck) disable iff (!trst_n)
    (ev_cap_dr && sel == SEL_BYPASS) |=> (sr == '0));

endmodule

// File: rtl/dbg_bus_ctl.sv
`timescale 1ns/100ps
module dbg_bus_ctl
  import dbg_jtag_pkg::*;
#(
  parameter int  ABITS = 7,
  localparam int DW    = ABITS + 34
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             ev_upd_dr,
  input  dr_sel_t          sel,
  input  logic [DW-1:0]    sr,
  input  logic [31:0]      dbus_rdata,
  input  logic             dbus_err,
  output logic [ABITS-1:0] dbus_addr,
  output logic [31:0]      dbus_wdata,
  output logic             dbus_rd,
  output logic             dbus_wr,
  output logic [DW-1:0]    cap_word
);

  logic [ABITS-1:0] cmd_addr;
  logic [31:0]      cmd_data;
  logic [1:0]       cmd_op;
  logic             issue;
  logic [31:0]      res_data;
  logic [1:0]       res_st;
  logic [ABITS-1:0] addr_q;
  logic [31:0]      wdata_q;

  assign cmd_addr = sr[DW-1:34];
  assign cmd_data = sr[33:2];
  assign cmd_op   = sr[1:0];
  assign issue    = ev_upd_dr && (sel == SEL_BUS);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      res_data <= '0;
      res_st   <= ST_OK;
      dbus_rd  <= 1'b0;
      dbus_wr  <= 1'b0;
    end else if (issue) begin
      addr_q   <= cmd_addr;
      wdata_q  <= cmd_data;
      res_data <= cmd_data;
      dbus_rd  <= (cmd_op == OP_READ);
      dbus_wr  <= (cmd_op == OP_WRITE);
      res_st   <= (cmd_op == OP_RSVD) ? ST_FAIL : ST_OK;
    end else if (dbus_rd || dbus_wr) begin
      dbus_rd <= 1'b0;
      dbus_wr <= 1'b0;
      res_st  <= dbus_err ? ST_FAIL : ST_OK;
      if (dbus_rd && !dbus_err) res_data <= dbus_rdata;
    end
  end

  assign dbus_addr  = addr_q;
  assign dbus_wdata = wdata_q;
  assign cap_word   = {addr_q, res_data, res_st};

  assert_strobe_excl_R11: assert property (@(posedge tck) disable iff (!trst_n)
    !(dbus_rd && dbus_wr));

  assert_strobe_pulse_R11: assert property (@(posedge tck) disable iff (!trst_n)
    (dbus_rd || dbus_wr) |=> !(dbus_rd || dbus_wr));

  assert_read_issue_R6: assert property (@(posedge tck) disable iff (!trst_n)
    (issue && cmd_op == OP_READ) |=> dbus_rd);

  assert_write_issue_R5: assert property (@(posedge tck) disable iff (!trst_n)
    (issue && cmd_op == OP_WRITE) |=> (dbus_wr && dbus_wdata == $past(cmd_data)));

  assert_no_strobe_R8: assert property (@(posedge tck) disable iff (!trst_n)
    (issue && (cmd_op == OP_NOP || cmd_op == OP_RSVD)) |=> !(dbus_rd || dbus_wr));

  assert_err_status_R7: assert property (@(posedge tck) disable iff (!trst_n)
    ((dbus_rd || dbus_wr) && dbus_err) |=> (cap_word[1:0] == ST_FAIL));

endmodule

// File: rtl/dbg_jtag_bridge.sv
`timescale 1ns/100ps
module dbg_jtag_bridge
  import dbg_jtag_pkg::*;
#(
  parameter int          ABITS  = 7,
  parameter logic [31:0] IDCODE = 32'h1E57_A0C3,
  localparam int         DW     = ABITS + 34
) (
  input  logic             tck,
  input  logic             tms,
  input  logic             tdi,
  input  logic             trst_n,
  output logic             tdo,
  output logic [ABITS-1:0] dbus_addr,
  output logic [31:0]      dbus_wdata,
  output logic             dbus_rd,
  output logic             dbus_wr,
  input  logic [31:0]      dbus_rdata,
  input  logic             dbus_err
);

  tap_state_t      state;
  logic            to_reset;
  logic            ev_cap_dr, ev_sh_dr, ev_upd_dr;
  logic            ev_cap_ir, ev_sh_ir, ev_upd_ir;
  logic [IR_W-1:0] ir_sr;
  logic [IR_W-1:0] ir_q;
  dr_sel_t         sel;
  logic [DW-1:0]   sr;
  logic [DW-1:0]   cap_word;

  dbg_tap_ctrl u_tap (
    .tck       (tck),
    .trst_n    (trst_n),
    .tms       (tms),
    .state     (state),
    .to_reset  (to_reset),
    .ev_cap_dr (ev_cap_dr),
    .ev_sh_dr  (ev_sh_dr),
    .ev_upd_dr (ev_upd_dr),
    .ev_cap_ir (ev_cap_ir),
    .ev_sh_ir  (ev_sh_ir),
    .ev_upd_ir (ev_upd_ir)
  );

  dbg_ir_reg u_ir (
    .tck       (tck),
    .trst_n    (trst_n),
    .tdi       (tdi),
    .to_reset  (to_reset),
    .ev_cap_ir (ev_cap_ir),
    .ev_sh_ir  (ev_sh_ir),
    .ev_upd_ir (ev_upd_ir),
    .state     (state),
    .ir_sr     (ir_sr),
    .ir_q      (ir_q),
    .sel       (sel)
  );

  dbg_dr_path #(.ABITS(ABITS), .IDCODE(IDCODE)) u_dr (
    .tck       (tck),
    .trst_n    (trst_n),
    .tdi       (tdi),
    .ev_cap_dr (ev_cap_dr),
    .ev_sh_dr  (ev_sh_dr),
    .sel       (sel),
    .cap_bus   (cap_word),
    .sr        (sr)
  );

  dbg_bus_ctl #(.ABITS(ABITS)) u_bus (
    .tck        (tck),
    .trst_n     (trst_n),
    .ev_upd_dr  (ev_upd_dr),
    .sel        (sel),
    .sr         (sr),
    .dbus_rdata (dbus_rdata),
    .dbus_err   (dbus_err),
    .dbus_addr  (dbus_addr),
    .dbus_wdata (dbus_wdata),
    .dbus_rd    (dbus_rd),
    .dbus_wr    (dbus_wr),
    .cap_word   (cap_word)
  );

  // Output stage on the falling edge.
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)         tdo <= 1'b0;
    else if (ev_sh_ir)   tdo <= ir_sr[0];
    else if (ev_sh_dr)   tdo <= sr[0];
    else                 tdo <= 1'b0;
  end

  assert_tdo_quiet_R10: assert property (@(posedge tck) disable iff (!trst_n)
    !(state == TS_SH_IR || state == TS_SH_DR) |-> !tdo);

endmodule

// File: tb/sim_dbg_jtag_bridge.sv
`timescale 1ns/100ps
module sim_dbg_jtag_bridge;
  import dbg_jtag_pkg::*;

  localparam int          ABITS = 7;
  localparam int          DW    = ABITS + 34;
  localparam logic [31:0] IDC   = 32'h1E57_A0C3;
  localparam logic [31:0] CSR_EXP = 32'h0000_0071;  // (7 << 4) | 1

  logic tck = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic trst_n = 1'b0;
  logic tdo;
  logic [ABITS-1:0] dbus_addr;
  logic [31:0] dbus_wdata, dbus_rdata;
  logic dbus_rd, dbus_wr, dbus_err;

  int errors = 0;
  int checks = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  bit done = 0;
  logic [31:0] mem [16];

  always #2.5 tck = ~tck;

  dbg_jtag_bridge #(.ABITS(ABITS), .IDCODE(IDC)) u0 (
    .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n), .tdo(tdo),
    .dbus_addr(dbus_addr), .dbus_wdata(dbus_wdata),
    .dbus_rd(dbus_rd), .dbus_wr(dbus_wr),
    .dbus_rdata(dbus_rdata), .dbus_err(dbus_err)
  );

  // Debug-module model: 16 words, addresses 16 and up fail.
  assign dbus_err   = (dbus_rd || dbus_wr) && (dbus_addr >= 16);
  assign dbus_rdata = (dbus_addr < 16) ? mem[dbus_addr[3:0]] : 32'hBAD0_BAD0;

  always @(posedge tck) begin
    if (dbus_rd) rd_cnt++;
    if (dbus_wr) begin
      wr_cnt++;
      if (dbus_addr < 16) mem[dbus_addr[3:0]] <= dbus_wdata;
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic m, logic d);
    @(negedge tck); #1;
    tms = m; tdi = d;
    @(posedge tck);
  endtask

  task automatic tap_reset();
    repeat (5) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic shift_ir(logic [4:0] v, output logic [4:0] o);
    o = '0;
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    for (int i = 0; i < 5; i++) begin
      @(negedge tck); #1;
      o[i] = tdo;
      tms = (i == 4);
      tdi = v[i];
      @(posedge tck);
    end
    step(1'b1, 1'b0); step(1'b0, 1'b0);
  endtask

  task automatic shift_dr(logic [63:0] v, int len, output logic [63:0] o);
    o = '0;
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    for (int i = 0; i < len; i++) begin
      @(negedge tck); #1;
      o[i] = tdo;
      tms = (i == len - 1);
      tdi = v[i];
      @(posedge tck);
    end
    step(1'b1, 1'b0); step(1'b0, 1'b0);
  endtask

  function automatic logic [63:0] cmd(int a, logic [31:0] d, logic [1:0] op);
    logic [ABITS-1:0] aa;
    aa = ABITS'(a);
    return 64'({aa, d, op});
  endfunction

  task automatic t_reset_ident();
    logic [63:0] o;
    #1;
    check("R10 tdo low in reset", 64'(tdo), 64'd0);
    step(1'b0, 1'b0);
    shift_dr(64'd0, 32, o);
    check("R2 ident after reset", o, 64'(IDC));
    @(negedge tck); #1;
    check("R10 tdo low in idle", 64'(tdo), 64'd0);
  endtask

  task automatic t_ir_csr();
    logic [4:0] io;
    logic [63:0] o;
    shift_ir(INS_XPORT_CS, io);
    check("R1 IR capture pattern", 64'(io), 64'h01);
    shift_dr(64'hFFFF_FFFF, 32, o);
    check("R3 status word", o, 64'(CSR_EXP));
    shift_dr(64'd0, 32, o);
    check("R3 status word after update ignored", o, 64'(CSR_EXP));
  endtask

  task automatic t_bus_reset();
    logic [4:0] io;
    logic [63:0] o;
    int r0, w0;
    shift_ir(INS_BUS_ACC, io);
    r0 = rd_cnt; w0 = wr_cnt;
    shift_dr(cmd(0, 32'd0, OP_NOP), DW, o);
    check("R4 bus register reset value", o, 64'd0);
  endtask

  task automatic t_write_ok();
    logic [63:0] o;
    int w0;
    w0 = wr_cnt;
    shift_dr(cmd(3, 32'hDEAD_BEEF, OP_WRITE), DW, o);
    shift_dr(cmd(0, 32'd0, OP_NOP), DW, o);
    check("R5 write result word", o, cmd(3, 32'hDEAD_BEEF, ST_OK));
    check("R5 memory written", 64'(mem[3]), 64'hDEAD_BEEF);
    check("R11 single write pulse", 64'(wr_cnt - w0), 64'd1);
  endtask

  task automatic t_read_ok();
    logic [63:0] o;
    int r0;
    r0 = rd_cnt;
    shift_dr(cmd(5, 32'd0, OP_READ), DW, o);
    shift_dr(cmd(0, 32'd0, OP_NOP), DW, o);
    check("R6 read result word", o, cmd(5, 32'hA5A5_0005, ST_OK));
    check("R11 single read pulse", 64'(rd_cnt - r0), 64'd1);
    shift_dr(cmd(3, 32'd0, OP_READ), DW, o);
    shift_dr(cmd(0, 32'd0, OP_NOP), DW, o);
    check("R6 read back written word", o, cmd(3, 32'hDEAD_BEEF, ST_OK));
  endtask

  task automatic t_errors();
    logic [63:0] o;
    shift_dr(cmd(20, 32'h0000_CAFE, OP_READ), DW, o);
    shift_dr(cmd(0, 32'd0, OP_NOP), DW, o);
    check("R7 failed read status", o, cmd(20, 32'h0000_CAFE, ST_FAIL));
    shift_dr(cmd(25, 32'h0000_1234, OP_WRITE), DW, o);
    shift_dr(cmd(0, 32'd0, OP_NOP), DW, o);
    check("R5 failed write status", o, cmd(25, 32'h0000_1234, ST_FAIL));
  endtask

  task automatic t_nop_rsvd();
    logic [63:0] o;
    int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    shift_dr(cmd(9, 32'h0000_0077, OP_NOP), DW, o);
    shift_dr(cmd(9, 32'h0000_0088, OP_RSVD), DW, o);
    check("R8 no-op echo", o, cmd(9, 32'h0000_0077, ST_OK));
    shift_dr(cmd(0, 32'd0, OP_NOP), DW, o);
    check("R8 reserved op status", o, cmd(9, 32'h0000_0088, ST_FAIL));
    check("R8 no strobes", 64'((rd_cnt - r0) + (wr_cnt - w0)), 64'd0);
  endtask

  task automatic t_bypass();
    logic [4:0] io;
    logic [63:0] o;
    shift_ir(INS_RESET_REQ, io);
    shift_dr(64'hB3, 8, o);
    check("R9 bypass on reset code", o, 64'h66);
    shift_ir(5'h05, io);
    shift_dr(64'h5A, 8, o);
    check("R9 bypass on unknown code", o, 64'hB4);
  endtask

  task automatic t_tap_reset();
    logic [4:0] io;
    logic [63:0] o;
    shift_ir(INS_BUS_ACC, io);
    tap_reset();
    shift_dr(64'd0, 32, o);
    check("R2 ident after five TMS high", o, 64'(IDC));
    shift_ir(INS_XPORT_CS, io);
    @(negedge tck); #1;
    trst_n = 1'b0;
    #3;
    trst_n = 1'b1;
    step(1'b0, 1'b0);
    shift_dr(64'd0, 32, o);
    check("R2 ident after async reset", o, 64'(IDC));
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'hA5A5_0000 + 32'(i);
    #12;
    trst_n = 1'b1;
    t_reset_ident();
    t_ir_csr();
    t_bus_reset();
    t_write_ok();
    t_read_ok();
    t_errors();
    t_nop_rsvd();
    t_bypass();
    t_tap_reset();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule